// File: doc/BRIEF.md
# Event Counter and Watchdog with Shared Divider

This block combines an 8-bit event counter and a watchdog timer around a single 8-bit divider chain. A configuration register hands the divider to one of the two at a time. When the counter owns it, the divider sits in front of the counter and slows its count. When the watchdog owns it, the divider follows the watchdog's base stage and stretches the time-out period. Software can load and read the counter over a narrow data port. Software cannot see the divider at all.

The counter can count every system clock cycle, or it can count edges of an external pin. The pin is synchronized first, and either the rising or the falling edge can be chosen. When the counter wraps from its top value to zero, it can raise a one-cycle interrupt pulse, under an enable bit. The watchdog runs only while a static fuse-level enable is high. A clear strobe restarts it. On a time-out it drives a one-cycle reset pulse.

The configuration word `cfg_wdata` has these fields:
- Bits [2:0] are the divide rate k.
- Bit 3 gives the divider to the watchdog (1) or to the counter (0).
- Bit 4 selects the falling pin edge (1) or the rising pin edge (0).
- Bit 5 selects the external pin as the source (1) or the system clock (0).
- Bit 6 enables the rollover interrupt.

Top module: `timer_watchdog`

## Requirements
- R1: After a synchronous reset, `cnt_rdata` is 0, `irq` is 0 and `wdt_rst` is 0, and the configuration is all zeros.
- R2: A cycle with `cnt_we` high loads `cnt_wdata` into the counter, and no count step happens in that cycle. The loaded value appears on `cnt_rdata` one cycle later.
- R3: When bit 3 is 0, the counter advances once for every 2^(k+1) source events, where k is bits [2:0]. This gives rates from 1:2 (k=0) to 1:256 (k=7). Without an event or a write, the counter holds its value.
- R4: When bit 3 is 1, the counter advances once on every source event, with no division.
- R5: When bit 5 is 1, the counter counts edges of `ext_pin` after a two-flop synchronizer. Bit 4 = 0 counts rising edges and bit 4 = 1 counts falling edges. The opposite edge has no effect. A pin change driven before clock edge 1 first shows on `cnt_rdata` after clock edge 3.
- R6: A wrap of the counter from 0xFF to 0x00 produces a one-cycle `irq` pulse, one cycle after the wrap step, but only if bit 6 is 1.
- R7: A counter write while bit 3 is 0 clears the divider, so the next count step comes a full divide period after the write.
- R8: With the fuse enable high and bit 3 at 0, the 2^WDT_BASE_W-th `wdt_tick` after a clear causes a one-cycle `wdt_rst` pulse in the following cycle. With the default of 3, this is the 8th tick.
- R9: With bit 3 at 1, the time-out comes after 2^WDT_BASE_W * 2^(k+1) ticks. With the defaults and k=1, this is the 32nd tick.
- R10: A `wdt_clr` pulse restarts the watchdog period and clears the divider.
- R11: While `wdt_fuse_en` is low, the watchdog is held cleared and `wdt_rst` never rises.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration register write strobe |
| cfg_wdata | input | 7 | Configuration word (fields listed above) |
| cnt_we | input | 1 | Counter write strobe |
| cnt_wdata | input | CNT_W | Counter load value |
| cnt_rdata | output | CNT_W | Current counter value |
| ext_pin | input | 1 | Asynchronous external count pin |
| wdt_tick | input | 1 | One-cycle tick from the watchdog oscillator |
| wdt_clr | input | 1 | Watchdog clear strobe |
| wdt_fuse_en | input | 1 | Static fuse-level watchdog enable |
| irq | output | 1 | Rollover interrupt pulse |
| wdt_rst | output | 1 | Watchdog reset pulse |

## Verification
The assertions check these properties on every cycle:
- A counter write lands one cycle later.
- The counter holds without an event.
- Interrupt and reset pulses last exactly one cycle.
- An interrupt requires the enable.
- A clear empties the divider.
- A synchronized edge is a single-cycle event.
- A low fuse enable blocks any reset.

The bench scenarios are needed for the counting results:
- the actual divide ratios,
- the three-cycle pin latency,
- the ignored opposite edge,
- the exact tick on which each watchdog time-out occurs,
- the restart effect of the clear strobe and of a counter write.

// File: rtl/tw_pkg.sv
package tw_pkg;
  localparam int CFG_W = 7;

  typedef struct packed {
    logic       irq_en;
    logic       src_ext;
    logic       edge_fall;
    logic       to_wdt;
    logic [2:0] rate;
  } cfg_t;
endpackage

// File: rtl/tw_pin_sync.sv
module tw_pin_sync #(
  parameter int SYNC_N = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin,
  input  logic edge_fall,
  output logic evt
);
  localparam int SH_W = SYNC_N + 1;

  logic [SH_W-1:0] sh_q;
  logic            cur_lvl;
  logic            old_lvl;

  always_ff @(posedge clk) begin
    if (rst) sh_q <= '0;
    else     sh_q <= {sh_q[SH_W-2:0], pin};
  end

  assign cur_lvl = sh_q[SYNC_N-1];
  assign old_lvl = sh_q[SYNC_N];

  always_comb begin
    if (edge_fall) evt = old_lvl & ~cur_lvl;
    else           evt = cur_lvl & ~old_lvl;
  end

  // R5: a detected edge lasts a single cycle
  p_edge_single_r5: assert property (@(posedge clk) disable iff (rst)
    evt |=> !evt);
endmodule

// File: rtl/tw_prescaler.sv
module tw_prescaler #(
  parameter int PSC_W  = 8,
  parameter int RATE_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              in_evt,
  input  logic [RATE_W-1:0] rate,
  output logic              out_evt
);
  logic [PSC_W-1:0] psc_q;
  logic [PSC_W-1:0] mask;

  always_comb begin
    for (int i = 0; i < PSC_W; i++) begin
      mask[i] = (RATE_W'(i) <= rate);
    end
  end

  assign out_evt = in_evt && ((psc_q & mask) == mask);

  always_ff @(posedge clk) begin
    if (rst || clr)  psc_q <= '0;
    else if (in_evt) psc_q <= psc_q + 1'b1;
  end

  // R7 / R10: a clear request empties the divider chain
  p_clear_empties_r7: assert property (@(posedge clk) disable iff (rst)
    clr |=> psc_q == '0);
endmodule

// File: rtl/tw_counter.sv
module tw_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [CNT_W-1:0] wdata,
  input  logic             inc,
  input  logic             irq_en,
  output logic [CNT_W-1:0] cnt_q,
  output logic             irq_q
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic wrap;

  assign wrap = inc && !we && (cnt_q == CNT_MAX);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      irq_q <= 1'b0;
    end else begin
      if (we)       cnt_q <= wdata;
      else if (inc) cnt_q <= cnt_q + 1'b1;
      irq_q <= wrap && irq_en;
    end
  end

  p_load_r2: assert property (@(posedge clk) disable iff (rst)
    we |=> cnt_q == $past(wdata));

  p_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (!we && !inc) |=> $stable(cnt_q));

  p_irq_pulse_r6: assert property (@(posedge clk) disable iff (rst)
    irq_q |=> !irq_q);

  p_irq_needs_en_r6: assert property (@(posedge clk) disable iff (rst)
    irq_q |-> $past(irq_en));
endmodule

// File: rtl/tw_watchdog.sv
module tw_watchdog #(
  parameter int BASE_W = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic fuse_en,
  input  logic clr,
  input  logic use_psc,
  input  logic psc_out,
  output logic base_evt,
  output logic timeout,
  output logic wdt_rst_q
);
  localparam logic [BASE_W-1:0] BASE_MAX = '1;

  logic [BASE_W-1:0] base_q;

  assign base_evt = fuse_en && tick && (base_q == BASE_MAX);
  assign timeout  = fuse_en && (use_psc ? psc_out : base_evt);

  always_ff @(posedge clk) begin
    if (rst || !fuse_en || clr) base_q <= '0;
    else if (tick)              base_q <= base_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) wdt_rst_q <= 1'b0;
    else     wdt_rst_q <= timeout;
  end

  p_rst_pulse_r8: assert property (@(posedge clk) disable iff (rst)
    wdt_rst_q |=> !wdt_rst_q);

  p_fuse_blocks_r11: assert property (@(posedge clk) disable iff (rst)
    !fuse_en |=> !wdt_rst_q);

  p_clr_restarts_r10: assert property (@(posedge clk) disable iff (rst)
    clr |=> base_q == '0);
endmodule

// File: rtl/timer_watchdog.sv
module timer_watchdog
  import tw_pkg::*;
#(
  parameter int CNT_W      = 8,
  parameter int PSC_W      = 8,
  parameter int WDT_BASE_W = 3,
  parameter int SYNC_N     = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_we,
  input  logic [CFG_W-1:0] cfg_wdata,
  input  logic             cnt_we,
  input  logic [CNT_W-1:0] cnt_wdata,
  output logic [CNT_W-1:0] cnt_rdata,
  input  logic             ext_pin,
  input  logic             wdt_tick,
  input  logic             wdt_clr,
  input  logic             wdt_fuse_en,
  output logic             irq,
  output logic             wdt_rst
);
  localparam int RATE_W = $clog2(PSC_W);

  cfg_t cfg_q;
  logic pin_evt;
  logic src_evt;
  logic psc_in;
  logic psc_out;
  logic psc_clr;
  logic cnt_inc;
  logic base_evt;
  logic timeout;

  always_ff @(posedge clk) begin
    if (rst)         cfg_q <= '0;
    else if (cfg_we) cfg_q <= cfg_t'(cfg_wdata);
  end

  tw_pin_sync #(.SYNC_N(SYNC_N)) u_sync (
    .clk       (clk),
    .rst       (rst),
    .pin       (ext_pin),
    .edge_fall (cfg_q.edge_fall),
    .evt       (pin_evt)
  );

  assign src_evt = cfg_q.src_ext ? pin_evt : 1'b1;
  assign psc_in  = cfg_q.to_wdt ? base_evt : src_evt;
  assign psc_clr = wdt_clr || (cnt_we && !cfg_q.to_wdt) || (timeout && cfg_q.to_wdt);
  assign cnt_inc = cfg_q.to_wdt ? src_evt : psc_out;

  tw_prescaler #(.PSC_W(PSC_W), .RATE_W(RATE_W)) u_psc (
    .clk     (clk),
    .rst     (rst),
    .clr     (psc_clr),
    .in_evt  (psc_in),
    .rate    (RATE_W'(cfg_q.rate)),
    .out_evt (psc_out)
  );

  tw_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk    (clk),
    .rst    (rst),
    .we     (cnt_we),
    .wdata  (cnt_wdata),
    .inc    (cnt_inc),
    .irq_en (cfg_q.irq_en),
    .cnt_q  (cnt_rdata),
    .irq_q  (irq)
  );

  tw_watchdog #(.BASE_W(WDT_BASE_W)) u_wdt (
    .clk       (clk),
    .rst       (rst),
    .tick      (wdt_tick),
    .fuse_en   (wdt_fuse_en),
    .clr       (wdt_clr),
    .use_psc   (cfg_q.to_wdt),
    .psc_out   (psc_out),
    .base_evt  (base_evt),
    .timeout   (timeout),
    .wdt_rst_q (wdt_rst)
  );
endmodule

// File: tb/timer_watchdog_tb_top.sv
module timer_watchdog_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cfg_we = 1'b0;
  logic [6:0] cfg_wdata = '0;
  logic       cnt_we = 1'b0;
  logic [7:0] cnt_wdata = '0;
  logic [7:0] cnt_rdata;
  logic       ext_pin = 1'b0;
  logic       wdt_tick = 1'b0;
  logic       wdt_clr = 1'b0;
  logic       wdt_fuse_en = 1'b0;
  logic       irq;
  logic       wdt_rst;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  timer_watchdog dut_i (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .cnt_we(cnt_we), .cnt_wdata(cnt_wdata), .cnt_rdata(cnt_rdata),
    .ext_pin(ext_pin), .wdt_tick(wdt_tick), .wdt_clr(wdt_clr),
    .wdt_fuse_en(wdt_fuse_en), .irq(irq), .wdt_rst(wdt_rst)
  );

  // {cfg[7:0], cycles[15:0], expected count[7:0]}, internal source
  localparam logic [31:0] VEC [6] = '{
    {8'h00, 16'd10,  8'd5},
    {8'h02, 16'd20,  8'd2},
    {8'h07, 16'd600, 8'd2},
    {8'h08, 16'd37,  8'd37},
    {8'h01, 16'd3,   8'd0},
    {8'h04, 16'd64,  8'd2}
  };

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic set_cfg(input logic [6:0] v);
    cfg_we = 1'b1; cfg_wdata = v;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic wr_cnt(input logic [7:0] v);
    cnt_we = 1'b1; cnt_wdata = v;
    @(negedge clk);
    cnt_we = 1'b0;
  endtask

  task automatic clr_pulse();
    wdt_clr = 1'b1;
    @(negedge clk);
    wdt_clr = 1'b0;
  endtask

  task automatic ticks(input int n, output int seen_at);
    seen_at = 0;
    for (int i = 1; i <= n; i++) begin
      wdt_tick = 1'b1;
      @(negedge clk);
      if (wdt_rst && seen_at == 0) seen_at = i;
    end
    wdt_tick = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int seen;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk("R1 cnt", cnt_rdata, 0);
    chk("R1 irq", irq, 0);
    chk("R1 wdt_rst", wdt_rst, 0);

    // R3 / R4 table walk
    for (int v = 0; v < 6; v++) begin
      set_cfg(VEC[v][30:24]);
      wr_cnt(8'h00);
      repeat (int'(VEC[v][23:8])) @(negedge clk);
      chk($sformatf("R3/R4 vec%0d", v), cnt_rdata, int'(VEC[v][7:0]));
    end

    // R2 load and R6 rollover with enable
    set_cfg(7'h48);
    wr_cnt(8'hFE);
    chk("R2 load", cnt_rdata, 8'hFE);
    @(negedge clk);
    chk("R6 pre", irq, 0);
    @(negedge clk);
    chk("R6 irq", irq, 1);
    chk("R6 wrap", cnt_rdata, 0);
    @(negedge clk);
    chk("R6 pulse", irq, 0);

    // R6 disabled
    set_cfg(7'h08);
    wr_cnt(8'hFE);
    seen = 0;
    repeat (3) begin
      @(negedge clk);
      if (irq) seen = 1;
    end
    chk("R6 disabled", seen, 0);
    chk("R6 disabled cnt", cnt_rdata, 1);

    // R5 rising edges with latency
    set_cfg(7'h28);
    wr_cnt(8'h00);
    ext_pin = 1'b1;
    repeat (2) @(negedge clk);
    chk("R5 latency", cnt_rdata, 0);
    @(negedge clk);
    chk("R5 rise", cnt_rdata, 1);
    ext_pin = 1'b0;
    repeat (4) @(negedge clk);
    chk("R5 fall ignored", cnt_rdata, 1);

    // R5 falling edges
    set_cfg(7'h38);
    wr_cnt(8'h00);
    ext_pin = 1'b1;
    repeat (4) @(negedge clk);
    chk("R5 rise ignored", cnt_rdata, 0);
    ext_pin = 1'b0;
    repeat (3) @(negedge clk);
    chk("R5 fall", cnt_rdata, 1);

    // R3 pin events through divider
    set_cfg(7'h20);
    wr_cnt(8'h00);
    repeat (4) begin
      ext_pin = 1'b1; repeat (4) @(negedge clk);
      ext_pin = 1'b0; repeat (4) @(negedge clk);
    end
    chk("R3 pin div2", cnt_rdata, 2);

    // R7 write clears divider
    set_cfg(7'h02);
    wr_cnt(8'h00);
    repeat (5) @(negedge clk);
    wr_cnt(8'h10);
    repeat (7) @(negedge clk);
    chk("R7 no early step", cnt_rdata, 8'h10);
    @(negedge clk);
    chk("R7 step", cnt_rdata, 8'h11);

    // R8 base time-out
    set_cfg(7'h00);
    wdt_fuse_en = 1'b1;
    clr_pulse();
    ticks(7, seen);
    chk("R8 before", seen, 0);
    ticks(1, seen);
    chk("R8 timeout", seen, 1);
    @(negedge clk);
    chk("R8 one cycle", wdt_rst, 0);

    // R9 postscaled time-out
    set_cfg(7'h09);
    clr_pulse();
    ticks(31, seen);
    chk("R9 before", seen, 0);
    ticks(1, seen);
    chk("R9 timeout", seen, 1);

    // R10 clear restarts
    set_cfg(7'h00);
    clr_pulse();
    ticks(6, seen);
    clr_pulse();
    ticks(6, seen);
    chk("R10 cleared", seen, 0);
    ticks(2, seen);
    chk("R10 resumed", seen, 2);

    // R11 fuse low
    wdt_fuse_en = 1'b0;
    @(negedge clk);
    ticks(20, seen);
    chk("R11 no reset", seen, 0);
    wdt_fuse_en = 1'b1;
    ticks(8, seen);
    chk("R11 restart", seen, 8);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule